// File: doc/BRIEF.md
# Power-Down Mode Controller

This block decides what a processor's sleep request does. It holds an 8-bit control register that software reads and writes. A small state machine moves between normal running, a light sleep mode and a deep standby mode. When a sleep request arrives, the standby-select bit chooses the target mode. While in standby, a pin-policy bit chooses whether the controlled outputs keep their last values or float at high impedance.

The register also holds per-module clock-stop bits. One of them gates the clock enable of a DMA engine. Four more gate the enables of generic peripherals. Two register writes are interlocked with peripheral activity. The standby bit cannot be raised while the watchdog is running. The DMA stop bit cannot be raised while a DMA transfer is in progress.

A wake input returns the controller from either low-power mode to running. An asynchronous reset also returns it to running, and clears the register.

Top module: `pwr_down_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the mode output is RUN (0), every clock enable is active (dma_clk_en=1, gen_clk_en_n=0) and both pin controls are 0.
- R2: On a clock edge where the mode is RUN and sleep_req is high, the mode becomes SLEEP (1) if the standby bit (bit 7) is 0, or STANDBY (2) if it is 1. The standby bit used is the value held before any write in that same cycle.
- R3: A write that would change the standby bit (bit 7) from 0 to 1 while wdt_running is high leaves that bit at 0. The other bits of the same write still take effect. A bit that is already 1 stays 1.
- R4: In STANDBY, pin-policy bit 6 = 0 gives pin_hold=1 and pin_hiz=0, and bit 6 = 1 gives pin_hiz=1 and pin_hold=0. Outside STANDBY both outputs are 0.
- R5: Bit 5 always reads 0, and writing 1 to it has no effect.
- R6: Outside STANDBY, dma_clk_en is the inverse of the DMA stop bit (bit 4). When the bit is cleared the enable returns, and the controller disturbs no other state.
- R7: A write that would change bit 4 from 0 to 1 while dma_busy is high leaves bit 4 at 0. Clearing bit 4 is always accepted.
- R8: Outside STANDBY, gen_clk_en_n[i] equals register bit i for i = 0..3 (1 = clock stopped). These bits have no interlock.
- R9: In STANDBY, dma_clk_en is 0 and every gen_clk_en_n bit is 1.
- R10: A wake input in SLEEP or STANDBY returns the mode to RUN on the next edge. wake in RUN and sleep_req outside RUN are ignored. Reset in any mode returns the controller to RUN.
- R11: reg_rdata reflects a write on the edge that accepts it. The fields are: bit 7 standby select, bit 6 pin policy, bit 4 DMA stop, bits 3..0 generic stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sleep_req | input | 1 | Sleep request strobe from the processor |
| wake | input | 1 | Interrupt / wake input |
| wdt_running | input | 1 | Watchdog is counting |
| dma_busy | input | 1 | DMA transfer in progress |
| mode | output | 2 | 0 RUN, 1 SLEEP, 2 STANDBY |
| dma_clk_en | output | 1 | DMA clock enable, active high |
| gen_clk_en_n | output | 4 | Generic peripheral clock enables, active low |
| pin_hold | output | 1 | Hold controlled outputs at last value |
| pin_hiz | output | 1 | Drive controlled outputs to high impedance |

## Verification
Two functions can fall in the same cycle. A register write can change the standby bit in the same cycle that sleep_req arrives. An interlocked write can also coincide with its activity input changing. The bench provokes both on purpose: it writes 0x00 together with a sleep request while standby is selected, and 0x80 together with a request while it is not. The mode that results must follow the old bit. Random stimulus then mixes writes, requests, wakes and activity inputs on every cycle. A behavioural model checks all of it.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    localparam int REG_W     = 8;
    localparam int SBY_BIT   = 7;
    localparam int HIZ_BIT   = 6;
    localparam int RSV_BIT   = 5;
    localparam int DMA_BIT   = 4;
    localparam int GEN_STOPS = 4;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN     = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_STANDBY = 2'd2
    } pdc_mode_e;

    typedef struct packed {
        logic                 sby;
        logic                 hiz;
        logic                 dma_stop;
        logic [GEN_STOPS-1:0] gen_stop;
    } pdc_cfg_t;

    typedef struct packed {
        pdc_mode_e mode;
    } pdc_fsm_t;
endpackage

// File: rtl/pdc_cfg_reg.sv
module pdc_cfg_reg
    import pdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             wdt_running,
    input  logic             dma_busy,
    output pdc_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);
    pdc_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            // raising an interlocked bit needs its activity input low
            cfg_d.sby      = wdata[SBY_BIT] & (cfg_q.sby | ~wdt_running);
            cfg_d.hiz      = wdata[HIZ_BIT];
            cfg_d.dma_stop = wdata[DMA_BIT] & (cfg_q.dma_stop | ~dma_busy);
            cfg_d.gen_stop = wdata[GEN_STOPS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata                  = '0;
        rdata[SBY_BIT]         = cfg_q.sby;
        rdata[HIZ_BIT]         = cfg_q.hiz;
        rdata[RSV_BIT]         = 1'b0;
        rdata[DMA_BIT]         = cfg_q.dma_stop;
        rdata[GEN_STOPS-1:0]   = cfg_q.gen_stop;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
    import pdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic      wake,
    input  logic      standby_sel,
    output pdc_mode_e mode
);
    pdc_fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (sleep_req)
                    st_d.mode = standby_sel ? MODE_STANDBY : MODE_SLEEP;
            end
            MODE_SLEEP, MODE_STANDBY: begin
                if (wake) st_d.mode = MODE_RUN;
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
endmodule

// File: rtl/pdc_out_ctrl.sv
module pdc_out_ctrl
    import pdc_pkg::*;
(
    input  pdc_mode_e            mode,
    input  pdc_cfg_t             cfg,
    output logic                 dma_clk_en,
    output logic [GEN_STOPS-1:0] gen_clk_en_n,
    output logic                 pin_hold,
    output logic                 pin_hiz
);
    logic deep;

    assign deep       = (mode == MODE_STANDBY);
    assign dma_clk_en = ~deep & ~cfg.dma_stop;
    assign pin_hiz    = deep & cfg.hiz;
    assign pin_hold   = deep & ~cfg.hiz;

    for (genvar g = 0; g < GEN_STOPS; g++) begin : g_gen_en
        assign gen_clk_en_n[g] = deep | cfg.gen_stop[g];
    end
endmodule

// File: rtl/pwr_down_ctrl.sv
module pwr_down_ctrl
    import pdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 sleep_req,
    input  logic                 wake,
    input  logic                 wdt_running,
    input  logic                 dma_busy,
    output logic [MODE_W-1:0]    mode,
    output logic                 dma_clk_en,
    output logic [GEN_STOPS-1:0] gen_clk_en_n,
    output logic                 pin_hold,
    output logic                 pin_hiz
);
    pdc_cfg_t  cfg;
    pdc_mode_e cur_mode;

    pdc_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wdata       (reg_wdata),
        .wdt_running (wdt_running),
        .dma_busy    (dma_busy),
        .cfg         (cfg),
        .rdata       (reg_rdata)
    );

    pdc_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .wake        (wake),
        .standby_sel (cfg.sby),
        .mode        (cur_mode)
    );

    pdc_out_ctrl u_out (
        .mode         (cur_mode),
        .cfg          (cfg),
        .dma_clk_en   (dma_clk_en),
        .gen_clk_en_n (gen_clk_en_n),
        .pin_hold     (pin_hold),
        .pin_hiz      (pin_hiz)
    );

    assign mode = cur_mode;
endmodule

// File: rtl/pdc_sva.sv
module pdc_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       sleep_req,
    input logic       wake,
    input logic       wdt_running,
    input logic       dma_busy,
    input logic [1:0] mode,
    input logic       dma_clk_en,
    input logic [3:0] gen_clk_en_n,
    input logic       pin_hold,
    input logic       pin_hiz
);
    a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && sleep_req && !reg_rdata[7]) |=> (mode == 2'd1));

    a_r2_enter_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && sleep_req && reg_rdata[7]) |=> (mode == 2'd2));

    a_r3_sby_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wdt_running && !reg_rdata[7]) |=> !reg_rdata[7]);

    a_r7_dma_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && dma_busy && !reg_rdata[4]) |=> !reg_rdata[4]);

    a_r4_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2) |-> (!pin_hiz && !pin_hold));

    a_r6_dma_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2) |-> (dma_clk_en == !reg_rdata[4]));

    a_r9_standby_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (!dma_clk_en && (&gen_clk_en_n)));

    a_r10_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && wake) |=> (mode == 2'd0));
endmodule

bind pwr_down_ctrl pdc_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rdata    (reg_rdata),
    .sleep_req    (sleep_req),
    .wake         (wake),
    .wdt_running  (wdt_running),
    .dma_busy     (dma_busy),
    .mode         (mode),
    .dma_clk_en   (dma_clk_en),
    .gen_clk_en_n (gen_clk_en_n),
    .pin_hold     (pin_hold),
    .pin_hiz      (pin_hiz)
);

// File: tb/tb_pwr_down_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_down_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       wake = 1'b0;
    logic       wdt_running = 1'b0;
    logic       dma_busy = 1'b0;
    logic [1:0] mode;
    logic       dma_clk_en;
    logic [3:0] gen_clk_en_n;
    logic       pin_hold;
    logic       pin_hiz;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    int         m_mode = 0;
    logic [7:0] m_reg = 8'h00;

    always #10 clk = ~clk;

    pwr_down_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .wake(wake),
        .wdt_running(wdt_running), .dma_busy(dma_busy), .mode(mode),
        .dma_clk_en(dma_clk_en), .gen_clk_en_n(gen_clk_en_n),
        .pin_hold(pin_hold), .pin_hiz(pin_hiz)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, updated on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0;
            m_reg  = 8'h00;
        end else begin
            logic [7:0] nr;
            if (m_mode == 0 && sleep_req) m_mode = m_reg[7] ? 2 : 1;
            else if (m_mode != 0 && wake) m_mode = 0;
            if (reg_wr) begin
                nr = reg_wdata & 8'hDF;
                if (wdt_running && !m_reg[7]) nr[7] = 1'b0;
                if (dma_busy && !m_reg[4]) nr[4] = 1'b0;
                m_reg = nr;
            end
        end
    end

    // compare every output against the model each cycle
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            bit sb;
            sb = (m_mode == 2);
            check("R11 rdata", reg_rdata, m_reg);
            check("R2 mode", mode, m_mode);
            check("R6 dma_clk_en", dma_clk_en, (!sb && !m_reg[4]) ? 1 : 0);
            check("R8 gen_clk_en_n", gen_clk_en_n, sb ? 4'hF : m_reg[3:0]);
            check("R4 pin_hiz", pin_hiz, (sb && m_reg[6]) ? 1 : 0);
            check("R4 pin_hold", pin_hold, (sb && !m_reg[6]) ? 1 : 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit wr, input logic [7:0] wd, input bit slp, input bit wk);
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd; sleep_req = slp; wake = wk;
        @(posedge clk);
        #5;
        reg_wr = 1'b0; sleep_req = 1'b0; wake = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rdata", reg_rdata, 8'h00);
        check("R1 reset mode", mode, 0);
        check("R1 reset dma_clk_en", dma_clk_en, 1);
        check("R1 reset gen_clk_en_n", gen_clk_en_n, 0);
        check("R1 reset pins", {pin_hold, pin_hiz}, 0);
        @(negedge clk); rst_n = 1'b1;

        step(1, 8'hFF, 0, 0);
        check("R5 reserved bit reads 0", reg_rdata, 8'hDF);
        step(1, 8'h00, 0, 0);

        // R3 standby interlock
        wdt_running = 1'b1;
        step(1, 8'h81, 0, 0);
        check("R3 sby blocked, rest written", reg_rdata, 8'h01);
        wdt_running = 1'b0;
        step(1, 8'h80, 0, 0);
        check("R3 sby accepted when watchdog idle", reg_rdata, 8'h80);
        wdt_running = 1'b1;
        step(1, 8'hC0, 0, 0);
        check("R3 sby already set stays", reg_rdata, 8'hC0);
        wdt_running = 1'b0;
        step(1, 8'h00, 0, 0);

        // R7 DMA stop interlock, R6 enable
        dma_busy = 1'b1;
        step(1, 8'h1F, 0, 0);
        check("R7 dma stop blocked", reg_rdata, 8'h0F);
        check("R7 dma clock still on", dma_clk_en, 1);
        dma_busy = 1'b0;
        step(1, 8'h10, 0, 0);
        check("R6 dma clock removed", dma_clk_en, 0);
        dma_busy = 1'b1;
        step(1, 8'h00, 0, 0);
        check("R7 clear accepted while busy", reg_rdata, 8'h00);
        check("R6 dma clock back", dma_clk_en, 1);
        dma_busy = 1'b0;

        // R8 generic stops
        step(1, 8'h05, 0, 0);
        check("R8 generic enables", gen_clk_en_n, 4'h5);

        // R2 sleep, R10 exits
        step(0, 8'h00, 1, 0);
        check("R2 enter sleep", mode, 1);
        check("R8 sleep keeps generic enables", gen_clk_en_n, 4'h5);
        step(0, 8'h00, 1, 0);
        check("R10 sleep_req in sleep ignored", mode, 1);
        step(0, 8'h00, 0, 1);
        check("R10 wake from sleep", mode, 0);
        step(0, 8'h00, 0, 1);
        check("R10 wake in run ignored", mode, 0);

        // R9 and R4 standby
        step(1, 8'h80, 0, 0);
        step(0, 8'h00, 1, 0);
        check("R2 enter standby", mode, 2);
        check("R9 dma clock off", dma_clk_en, 0);
        check("R9 generic clocks off", gen_clk_en_n, 4'hF);
        check("R4 hold pins", {pin_hold, pin_hiz}, 2'b10);
        step(0, 8'h00, 0, 1);
        check("R10 wake from standby", mode, 0);
        check("R4 pins released", {pin_hold, pin_hiz}, 2'b00);
        step(1, 8'hC0, 0, 0);
        step(0, 8'h00, 1, 0);
        check("R4 high impedance", {pin_hold, pin_hiz}, 2'b01);
        @(negedge clk); rst_n = 1'b0;
        #2;
        check("R10 reset leaves standby", mode, 0);
        check("R1 reset clears register", reg_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // same-cycle write and sleep request: old standby bit decides
        step(1, 8'h80, 0, 0);
        step(1, 8'h00, 1, 0);
        check("R2 old sby=1 selects standby", mode, 2);
        step(0, 8'h00, 0, 1);
        step(1, 8'h80, 1, 0);
        check("R2 old sby=0 selects sleep", mode, 1);
        step(0, 8'h00, 0, 1);

        // random mix checked by the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            reg_wr      = ($urandom % 3) == 0;
            reg_wdata   = 8'($urandom);
            sleep_req   = ($urandom % 6) == 0;
            wake        = ($urandom % 5) == 0;
            wdt_running = ($urandom % 2) == 0;
            dma_busy    = ($urandom % 2) == 0;
        end
        @(negedge clk);
        reg_wr = 1'b0; sleep_req = 1'b0; wake = 1'b0;
        @(posedge clk); #6;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule